// File: doc/BRIEF.md
# MMU Region Lock Command Sequencer

This block carries out one maintenance operation on one address-space slot of a memory management unit. The host presents a slot number, a 64-bit start address, a 64-bit byte count and an 8-bit operation code. When the block accepts the request, it turns the range into a single naturally aligned power-of-two lock region. It writes that region as two 32-bit halves, waits for the slot to go idle, issues a lock command, waits again, and then issues the requested operation. After that it waits a third time until the slot reports idle, and only then reports completion.

The downstream side is a plain write bus. It carries a slot number, a 2-bit register select and 32-bit write data. Each slot returns a busy flag. The block samples the flag at a fixed poll interval. If the flag is still set when the total poll budget runs out, the block aborts, reports an error and raises a hang line that asks for a device reset. An unlock request skips the region step. The block accepts only one request at a time.

Top module: `mmu_lock_seq`

## Requirements
- R1: After reset, `req_ready_o` is high and `bus_we_o`, `done_o`, `err_o` and `hang_o` are low.
- R2: The lock word is computed as follows. Take `hb` as the 1-based index of the highest set bit of `start ^ (start + size - 1)` (0 if none). Take `w = max(hb, log2(MIN_LOCK_BYTES)) - 1`. The word is `start` with bits below `w` cleared, ORed with `w` in its low bits. Bits 31:0 are written with select 0 and bits 63:32 with select 1.
- R3: Start 0 with size all-ones gives `w = 63`, so the lock word is 0x3F, with no overflow from the end computation.
- R4: For any operation code other than unlock, the bus sees exactly four writes in this order: select 0, then select 1, then select 2 with data 0x02 (lock command), then select 2 with the operation code in bits 7:0.
- R5: For the unlock code 0x03, the region writes and the lock command are skipped. The only write is select 2 with data 0x03.
- R6: No select-2 write happens while the addressed slot's busy flag is set. The block waits for the flag to clear, and busy flags of other slots have no effect.
- R7: After the operation command, `done_o` pulses for one cycle with `err_o` low, and only after the addressed slot's busy flag has cleared.
- R8: If the busy flag is still set at the first poll sample taken at least `POLL_LIMIT` cycles into a wait, the sequence is abandoned. No further write is made, `done_o` and `err_o` pulse together, and `hang_o` rises and stays high until the next request is accepted.
- R9: While a sequence is running, `req_ready_o` is low and `req_valid_i` is ignored. A request held through the cycle of `done_o` is accepted in that same cycle.
- R10: Ranges smaller than the minimum region (32 KiB by default) give `w = 14`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_slot_i | input | SLOT_W | Target slot |
| req_start_i | input | ADDR_W | Range start address |
| req_size_i | input | ADDR_W | Range size in bytes |
| req_op_i | input | OP_W | Operation code (0x03 = unlock) |
| bus_we_o | output | 1 | Register write strobe |
| bus_slot_o | output | SLOT_W | Slot of the write |
| bus_sel_o | output | 2 | 0 lock low, 1 lock high, 2 command |
| bus_wdata_o | output | ADDR_W/2 | Write data |
| busy_i | input | NUM_SLOTS | Per-slot busy flags |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Timeout, valid with done_o |
| hang_o | output | 1 | Stuck-busy reset request |

## Verification
Two events can land in the same cycle: the completion pulse of one sequence and the acceptance of the next request. To provoke this, the bench keeps a second request valid while the first sequence is still running. It then checks that the acceptance cycle equals the done cycle, that no earlier acceptance happened, and that the write log holds all of the first sequence's writes before any of the second. A busy flag held on another slot while a sequence runs checks that only the addressed slot gates the commands.

// File: rtl/mmu_lock_pkg.sv
package mmu_lock_pkg;

  localparam int unsigned OP_W = 8;
  localparam logic [OP_W-1:0] OP_LOCK   = 8'h02;
  localparam logic [OP_W-1:0] OP_UNLOCK = 8'h03;

  typedef enum logic [1:0] {
    SEL_LOCK_LO = 2'd0,
    SEL_LOCK_HI = 2'd1,
    SEL_CMD     = 2'd2
  } reg_sel_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_LO,
    S_WR_HI,
    S_POLL_LOCK,
    S_CMD_LOCK,
    S_POLL_OP,
    S_CMD_OP,
    S_POLL_END
  } seq_state_e;

endpackage

// File: rtl/lock_region_enc.sv
module lock_region_enc #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned MIN_LOG2 = 15,
  localparam int unsigned WID_W   = $clog2(ADDR_W),
  localparam int unsigned HB_W    = WID_W + 1
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] size_i,
  output logic [ADDR_W-1:0] word_o,
  output logic [WID_W-1:0]  width_o
);

  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] diff;
  logic [HB_W-1:0]   hb;
  logic [HB_W-1:0]   eff;
  logic [ADDR_W-1:0] keep_mask;

  // modulo arithmetic: start 0 / size all-ones wraps harmlessly
  assign last_addr = start_i + size_i - ADDR_W'(1);
  assign diff      = start_i ^ last_addr;

  always_comb begin
    hb = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (diff[i]) hb = HB_W'(i + 1);
    end
  end

  assign eff       = (hb > HB_W'(MIN_LOG2)) ? hb : HB_W'(MIN_LOG2);
  assign width_o   = WID_W'(eff - HB_W'(1));
  assign keep_mask = {ADDR_W{1'b1}} << width_o;
  assign word_o    = (start_i & keep_mask) | ADDR_W'(width_o);

endmodule

// File: rtl/busy_poll_timer.sv
module busy_poll_timer #(
  parameter int unsigned INTERVAL = 4,
  parameter int unsigned LIMIT    = 64,
  localparam int unsigned IVL_W   = $clog2(INTERVAL + 1),
  localparam int unsigned TOT_W   = $clog2(LIMIT + 1) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic busy_i,
  output logic idle_o,
  output logic expired_o
);

  logic [IVL_W-1:0] ivl_q;
  logic [TOT_W-1:0] tot_q;
  logic             sample;

  assign sample    = active_i && (ivl_q == '0);
  assign idle_o    = sample && !busy_i;
  assign expired_o = sample && busy_i && (tot_q >= TOT_W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q <= '0;
      tot_q <= '0;
    end else if (!active_i) begin
      ivl_q <= '0;
      tot_q <= '0;
    end else begin
      ivl_q <= (ivl_q == IVL_W'(INTERVAL - 1)) ? '0 : ivl_q + IVL_W'(1);
      if (tot_q != {TOT_W{1'b1}}) tot_q <= tot_q + TOT_W'(1);
    end
  end

endmodule

// File: rtl/mmu_lock_seq.sv
module mmu_lock_seq
  import mmu_lock_pkg::*;
#(
  parameter int unsigned NUM_SLOTS      = 8,
  parameter int unsigned ADDR_W         = 64,
  parameter int unsigned MIN_LOCK_BYTES = 32768,
  parameter int unsigned POLL_INTERVAL  = 4,
  parameter int unsigned POLL_LIMIT     = 64,
  localparam int unsigned SLOT_W        = $clog2(NUM_SLOTS),
  localparam int unsigned HALF_W        = ADDR_W / 2,
  localparam int unsigned WID_W         = $clog2(ADDR_W),
  localparam int unsigned MIN_LOG2      = $clog2(MIN_LOCK_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [SLOT_W-1:0]    req_slot_i,
  input  logic [ADDR_W-1:0]    req_start_i,
  input  logic [ADDR_W-1:0]    req_size_i,
  input  logic [OP_W-1:0]      req_op_i,
  output logic                 bus_we_o,
  output logic [SLOT_W-1:0]    bus_slot_o,
  output logic [1:0]           bus_sel_o,
  output logic [HALF_W-1:0]    bus_wdata_o,
  input  logic [NUM_SLOTS-1:0] busy_i,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 hang_o
);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] word_q;
  logic              done_q, err_q, hang_q;

  logic [ADDR_W-1:0] enc_word;
  logic [WID_W-1:0]  enc_width;
  logic              accept;
  logic              poll_active, poll_idle, poll_expired;
  logic              finish_ok;
  logic              cmd_wr;

  lock_region_enc #(
    .ADDR_W   (ADDR_W),
    .MIN_LOG2 (MIN_LOG2)
  ) u_enc (
    .start_i (req_start_i),
    .size_i  (req_size_i),
    .word_o  (enc_word),
    .width_o (enc_width)
  );

  assign poll_active = (state_q == S_POLL_LOCK) || (state_q == S_POLL_OP) ||
                       (state_q == S_POLL_END);

  busy_poll_timer #(
    .INTERVAL (POLL_INTERVAL),
    .LIMIT    (POLL_LIMIT)
  ) u_poll (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (poll_active),
    .busy_i    (busy_i[slot_q]),
    .idle_o    (poll_idle),
    .expired_o (poll_expired)
  );

  assign req_ready_o = (state_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign finish_ok   = (state_q == S_POLL_END) && poll_idle;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (accept) state_d = (req_op_i == OP_UNLOCK) ? S_POLL_OP : S_WR_LO;
      S_WR_LO:     state_d = S_WR_HI;
      S_WR_HI:     state_d = S_POLL_LOCK;
      S_POLL_LOCK: if (poll_idle) state_d = S_CMD_LOCK;
      S_CMD_LOCK:  state_d = S_POLL_OP;
      S_POLL_OP:   if (poll_idle) state_d = S_CMD_OP;
      S_CMD_OP:    state_d = S_POLL_END;
      S_POLL_END:  if (poll_idle) state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
    if (poll_expired) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      slot_q  <= '0;
      op_q    <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      hang_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_ok || poll_expired;
      err_q   <= poll_expired;
      if (accept) begin
        slot_q <= req_slot_i;
        op_q   <= req_op_i;
        word_q <= enc_word;
        hang_q <= 1'b0;
      end else if (poll_expired) begin
        hang_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_we_o    = 1'b0;
    bus_sel_o   = SEL_CMD;
    bus_wdata_o = '0;
    unique case (state_q)
      S_WR_LO: begin
        bus_we_o    = 1'b1;
        bus_sel_o   = SEL_LOCK_LO;
        bus_wdata_o = word_q[HALF_W-1:0];
      end
      S_WR_HI: begin
        bus_we_o    = 1'b1;
        bus_sel_o   = SEL_LOCK_HI;
        bus_wdata_o = word_q[ADDR_W-1:HALF_W];
      end
      S_CMD_LOCK: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = HALF_W'(OP_LOCK);
      end
      S_CMD_OP: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = HALF_W'(op_q);
      end
      default: ;
    endcase
  end

  assign bus_slot_o = slot_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign hang_o     = hang_q;

  assign cmd_wr = bus_we_o && (bus_sel_o == SEL_CMD);

  assert_cmd_after_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |-> $past(poll_idle));

  assert_hi_after_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_sel_o == SEL_LOCK_HI) |-> $past(bus_we_o && bus_sel_o == SEL_LOCK_LO));

  assert_unlock_no_region_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_sel_o == SEL_LOCK_LO) |-> (op_q != OP_UNLOCK));

  assert_done_after_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> $past(poll_idle));

  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  assert_expire_aborts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_expired |=> (done_o && err_o && hang_o && req_ready_o));

  assert_hold_request_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> ($stable(word_q) && $stable(slot_q)));

  assert_width_floor_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_width >= WID_W'(MIN_LOG2 - 1));

  assert_full_space_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_start_i == '0 && &req_size_i) |-> (enc_width == WID_W'(ADDR_W - 1)));

endmodule

// File: tb/mmu_lock_seq_bench.sv
`timescale 1ns/1ps
module mmu_lock_seq_bench;

  localparam int NS       = 8;
  localparam int LIMIT    = 64;
  localparam int WD_LIMIT = 20000;

  typedef struct packed {
    logic [2:0]  slot;
    logic [7:0]  op;
    logic [7:0]  blen;
    logic [63:0] start;
    logic [63:0] size;
    logic [63:0] word;
  } vec_t;

  // R3 full space, R10 minimum floor, R2 general and high half, R5 unlock
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'h05, 8'd3, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3F},
    '{3'd1, 8'h04, 8'd0, 64'h1000_0000, 64'h1000, 64'h1000_000E},
    '{3'd2, 8'h04, 8'd6, 64'h1234_5000, 64'h2_0000, 64'h1234_0011},
    '{3'd7, 8'h05, 8'd2, 64'h8000_0001_0000_0000, 64'h8000, 64'h8000_0001_0000_000E},
    '{3'd3, 8'h03, 8'd5, 64'h0, 64'h0, 64'h0},
    '{3'd5, 8'h04, 8'd1, 64'h4000, 64'h4000, 64'h400E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_slot = '0;
  logic [63:0] req_start = '0;
  logic [63:0] req_size = '0;
  logic [7:0]  req_op = '0;
  logic        bus_we;
  logic [2:0]  bus_slot;
  logic [1:0]  bus_sel;
  logic [31:0] bus_wdata;
  logic [NS-1:0] busy;
  logic        done, err, hang;

  mmu_lock_seq u_mmu_lock_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_slot_i  (req_slot),
    .req_start_i (req_start),
    .req_size_i  (req_size),
    .req_op_i    (req_op),
    .bus_we_o    (bus_we),
    .bus_slot_o  (bus_slot),
    .bus_sel_o   (bus_sel),
    .bus_wdata_o (bus_wdata),
    .busy_i      (busy),
    .done_o      (done),
    .err_o       (err),
    .hang_o      (hang)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int busy_len = 0;
  int busy_cnt [NS];
  logic [NS-1:0] stuck = '0;
  logic [NS-1:0] hold = '0;

  logic [1:0]  lg_sel  [128];
  logic [31:0] lg_data [128];
  logic [2:0]  lg_slot [128];
  int log_n = 0, last_wr_cyc = 0, done_cyc = 0, accept_cyc = 0;
  int done_count = 0, accept_count = 0, viol = 0;
  logic done_err = 1'b0;

  always_comb
    for (int s = 0; s < NS; s++) busy[s] = (busy_cnt[s] != 0) || stuck[s] || hold[s];

  initial for (int s = 0; s < NS; s++) busy_cnt[s] = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int s = 0; s < NS; s++) begin
      if (bus_we && bus_sel == 2'd2 && int'(bus_slot) == s) busy_cnt[s] <= busy_len;
      else if (busy_cnt[s] > 0) busy_cnt[s] <= busy_cnt[s] - 1;
    end
    if (rst_n && bus_we) begin
      if (log_n < 128) begin
        lg_sel[log_n]  <= bus_sel;
        lg_data[log_n] <= bus_wdata;
        lg_slot[log_n] <= bus_slot;
      end
      log_n <= log_n + 1;
      last_wr_cyc <= cyc;
      if (bus_sel == 2'd2 && busy[bus_slot]) viol <= viol + 1;
    end
    if (rst_n && done) begin
      done_count <= done_count + 1;
      done_cyc   <= cyc;
      done_err   <= err;
    end
    if (rst_n && req_valid && req_ready) begin
      accept_count <= accept_count + 1;
      accept_cyc   <= cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog: actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] s, input logic [7:0] op, input logic [63:0] st, input logic [63:0] sz);
    int a0;
    @(negedge clk);
    req_slot = s; req_op = op; req_start = st; req_size = sz;
    a0 = accept_count;
    req_valid = 1'b1;
    do @(negedge clk); while (accept_count == a0);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_count == d0) @(negedge clk);
  endtask

  initial begin
    int base, d0, a0, n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(!bus_we && !done && !err && !hang, "R1 outputs low",
        64'({bus_we, done, err, hang}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && !bus_we, "R1 idle after release", 64'({req_ready, bus_we}), 64'b10);

    for (int v = 0; v < NV; v++) begin
      base = log_n;
      busy_len = int'(VECS[v].blen);
      d0 = done_count;
      issue(VECS[v].slot, VECS[v].op, VECS[v].start, VECS[v].size);
      wait_done(d0);
      n = log_n - base;
      if (VECS[v].op == 8'h03) begin
        chk(n == 1, "R5 unlock write count", 64'(n), 64'd1);
        chk(lg_sel[base] == 2'd2 && lg_data[base] == 32'h3, "R5 unlock command",
            64'(lg_data[base]), 64'h3);
      end else begin
        chk(n == 4, "R4 write count", 64'(n), 64'd4);
        chk(lg_sel[base] == 2'd0 && lg_data[base] == VECS[v].word[31:0], "R2 low half",
            64'({lg_sel[base], lg_data[base]}), 64'({2'd0, VECS[v].word[31:0]}));
        chk(lg_sel[base+1] == 2'd1 && lg_data[base+1] == VECS[v].word[63:32], "R2 high half",
            64'({lg_sel[base+1], lg_data[base+1]}), 64'({2'd1, VECS[v].word[63:32]}));
        chk(lg_sel[base+2] == 2'd2 && lg_data[base+2] == 32'h2, "R4 lock command",
            64'(lg_data[base+2]), 64'h2);
        chk(lg_sel[base+3] == 2'd2 && lg_data[base+3] == 32'(VECS[v].op), "R4 operation command",
            64'(lg_data[base+3]), 64'(VECS[v].op));
      end
      for (int k = 0; k < n && k < 4; k++)
        chk(lg_slot[base+k] == VECS[v].slot, "R6 write slot", 64'(lg_slot[base+k]), 64'(VECS[v].slot));
      chk(done_err == 1'b0, "R7 err clear", 64'(done_err), 64'd0);
      chk(done_cyc - last_wr_cyc > busy_len, "R7 waits for busy clear",
          64'(done_cyc - last_wr_cyc), 64'(busy_len + 1));
    end

    // R6 target slot busy at start: no command until released
    base = log_n; busy_len = 2; hold[4] = 1'b1; d0 = done_count;
    issue(3'd4, 8'h04, 64'h2_0000, 64'h100);
    repeat (20) @(negedge clk);
    n = 0;
    for (int k = base; k < log_n; k++) if (lg_sel[k] == 2'd2) n++;
    chk(n == 0, "R6 no command while busy", 64'(n), 64'd0);
    hold[4] = 1'b0;
    wait_done(d0);
    chk(log_n - base == 4 && done_err == 1'b0, "R6 completes after release",
        64'(log_n - base), 64'd4);

    // R6 other slot stuck has no effect
    stuck[6] = 1'b1; d0 = done_count; base = log_n;
    issue(3'd1, 8'h05, 64'h0, 64'h8000);
    wait_done(d0);
    chk(done_err == 1'b0 && log_n - base == 4, "R6 other slot ignored", 64'(done_err), 64'd0);
    stuck[6] = 1'b0;
    chk(viol == 0, "R6 command issued while busy", 64'(viol), 64'd0);

    // R9 refusal while running
    busy_len = 10; d0 = done_count; base = log_n;
    issue(3'd0, 8'h04, 64'h0, 64'h1000);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R9 ready low while running", 64'(req_ready), 64'd0);
    a0 = accept_count;
    req_slot = 3'd5; req_op = 8'h03; req_valid = 1'b1;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    chk(accept_count == a0, "R9 request ignored", 64'(accept_count), 64'(a0));
    wait_done(d0);
    chk(log_n - base == 4, "R9 no extra writes", 64'(log_n - base), 64'd4);

    // R9 next request accepted in the done cycle
    busy_len = 4; d0 = done_count; base = log_n;
    issue(3'd1, 8'h04, 64'h1000_0000, 64'h1000);
    req_slot = 3'd2; req_op = 8'h03; req_start = '0; req_size = '0;
    a0 = accept_count;
    req_valid = 1'b1;
    while (accept_count == a0) @(negedge clk);
    req_valid = 1'b0;
    chk(accept_cyc == done_cyc && done_count == d0 + 1, "R9 accept in done cycle",
        64'(accept_cyc), 64'(done_cyc));
    wait_done(d0 + 1);
    chk(log_n - base == 5 && lg_slot[base+3] == 3'd1 && lg_slot[base+4] == 3'd2 &&
        lg_data[base+4] == 32'h3, "R9 sequences in order", 64'(log_n - base), 64'd5);

    // R8 timeout
    stuck[2] = 1'b1; busy_len = 0; d0 = done_count; base = log_n;
    issue(3'd2, 8'h04, 64'h0, 64'h1000);
    wait_done(d0);
    chk(done_err == 1'b1, "R8 err on timeout", 64'(done_err), 64'd1);
    chk(hang == 1'b1, "R8 hang raised", 64'(hang), 64'd1);
    chk(log_n - base == 2, "R8 no command after abort", 64'(log_n - base), 64'd2);
    chk(done_cyc - accept_cyc >= LIMIT, "R8 timeout budget", 64'(done_cyc - accept_cyc), 64'(LIMIT));
    repeat (8) @(negedge clk);
    chk(hang == 1'b1 && log_n - base == 2, "R8 hang held", 64'(hang), 64'd1);
    stuck[2] = 1'b0; d0 = done_count;
    issue(3'd2, 8'h03, 64'h0, 64'h0);
    chk(hang == 1'b0, "R8 hang cleared on accept", 64'(hang), 64'd0);
    wait_done(d0);
    chk(done_err == 1'b0, "R8 recovery completes", 64'(done_err), 64'd0);

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule